// File: doc/BRIEF.md
# Read-Completion Data Error Reporter

This block sits beside the target side of a bus bridge. It acts on uncorrectable data errors that turn up while the bridge returns read-completion data. A bus decoder raises `err_strobe` for one clock in each data phase that carries such an error. The reporter then drives an active-low parity-error pulse after a fixed delay. The delay is two clocks in conventional bus mode and three clocks in extended bus mode. In the same cycle it can also drive an active-low system-error pulse and an abort towards the internal read completion.

Software observes the errors through two registers, both write-one-to-clear. A sticky status register records that an error was detected, that the bridge reported it as a master parity error, and that it raised a system error. An interrupt-status register is fed through one mask or enable per cause. When the extended mode runs its ECC sub-mode, the block also captures the two address words and the attribute word of the first failing transaction into a log record. The record is held until software releases it, and any later errors meanwhile set an overflow flag.

Top module: `rdcpl_err_ctrl`

## Requirements
- R1: With `mode_ext`=0 and `cmd_perr_resp`=1, a strobe in cycle 0 drives `perr_n` low for exactly cycle 2 only.
- R2: With `mode_ext`=1 and `cmd_perr_resp`=1, a strobe in cycle 0 drives `perr_n` low for exactly cycle 3 only.
- R3: With `cmd_perr_resp`=0, a strobe leaves `perr_n`, `serr_n` and `cpl_abort` inactive, and `sts[1]`, `sts[2]` are not set.
- R4: `serr_n` goes low only in the same cycle as the `perr_n` pulse, and only if `cmd_serr_en`=1 and `ctl_rec_en`=0 in the strobe cycle.
- R5: `cpl_abort` is high in exactly the cycle in which `perr_n` is low.
- R6: Status bits: `sts[0]` (detected) is set from cycle 1 after every strobe, whatever the enables. `sts[1]` (master parity) is set with the `perr_n` pulse. `sts[2]` (system error raised) is set with the `serr_n` pulse.
- R7: `irq_sts[0]`, `irq_sts[1]` and `irq_sts[2]` are set together with `sts[0]`, `sts[1]` and `sts[2]` respectively. Each is set only while its mask (`msk_dpe`, `msk_mpe`, `msk_serr`) is 0.
- R8: `irq_sts[3]` (system error seen) is set with the `serr_n` pulse only when `en_serr_det`=1.
- R9: A 1 in `w1c_sts` or `w1c_irq` clears that bit on the next edge, and a 0 leaves the bit alone. When a set and a clear of one bit land on the same edge, the bit stays set.
- R10: With `mode_ext`=1 and `mode_ecc`=1, a strobe while the log is free loads `err_addr_lo`, `err_addr_hi` and `err_attr` into the log and raises `log_valid` from cycle 1. In any other mode, nothing is logged.
- R11: While `log_valid`=1, the log contents hold and a further logged strobe sets `log_ovf`. A `log_clr` pulse drops both flags. A strobe in the same cycle as `log_clr` is captured as a fresh record with `log_ovf`=0.
- R12: Strobes in consecutive cycles each produce their own one-cycle `perr_n` pulse at the latency of R1 or R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_strobe | input | 1 | Uncorrectable data error in this data phase |
| err_addr_lo | input | ADDR_W | First address word of the failing transaction |
| err_addr_hi | input | ADDR_W | Second address word of the failing transaction |
| err_attr | input | ATTR_W | Attribute word of the failing transaction |
| mode_ext | input | 1 | 1 = extended bus mode (3-clock latency) |
| mode_ecc | input | 1 | ECC sub-mode of extended mode (enables logging) |
| cmd_perr_resp | input | 1 | Parity-error response enable |
| cmd_serr_en | input | 1 | System-error enable |
| ctl_rec_en | input | 1 | Uncorrectable-error recover enable (blocks system error) |
| msk_dpe | input | 1 | Mask for interrupt bit 0 |
| msk_mpe | input | 1 | Mask for interrupt bit 1 |
| msk_serr | input | 1 | Mask for interrupt bit 2 |
| en_serr_det | input | 1 | Enable for interrupt bit 3 |
| w1c_sts | input | 3 | Write-one-to-clear strobes for `sts` |
| w1c_irq | input | 4 | Write-one-to-clear strobes for `irq_sts` |
| log_clr | input | 1 | Releases the error log |
| perr_n | output | 1 | Parity-error pulse, active low |
| serr_n | output | 1 | System-error pulse, active low |
| cpl_abort | output | 1 | Abort internal read completion |
| sts | output | 3 | Sticky status: [0] detected, [1] master parity, [2] system error raised |
| irq_sts | output | 4 | Interrupt status: [0] detected, [1] master parity, [2] system error raised, [3] system error seen |
| log_valid | output | 1 | Log holds a record |
| log_ovf | output | 1 | Errors arrived while log was held |
| log_addr_lo | output | ADDR_W | Logged first address word |
| log_addr_hi | output | ADDR_W | Logged second address word |
| log_attr | output | ATTR_W | Logged attribute word |

## Verification
Two pairs of events can meet on one clock edge. The first pair is a software clear and a new hardware set of the same status or interrupt bit. The second pair is a log release and a newly logged error. The bench provokes each pair by raising `err_strobe` in the same cycle as `w1c_sts[0]`/`w1c_irq[0]`, and again in the same cycle as `log_clr`. It then reads the registers one cycle later. The bits must read set, the log must hold the new addresses and `log_ovf` must read 0.

// File: rtl/rdcpl_err_pkg.sv
package rdcpl_err_pkg;

  // Status bit positions (software view)
  localparam int STS_DPE  = 0;
  localparam int STS_MPE  = 1;
  localparam int STS_SERR = 2;
  localparam int STS_W    = 3;

  // Interrupt-status bit positions
  localparam int IRQ_DPE  = 0;
  localparam int IRQ_MPE  = 1;
  localparam int IRQ_SERR = 2;
  localparam int IRQ_SDET = 3;
  localparam int IRQ_W    = 4;

  // One token per errored data phase, carried down the delay line
  typedef struct packed {
    logic perr;  // parity-error pulse wanted
    logic serr;  // system-error pulse wanted
    logic ext;   // latency class: 1 = extended mode
  } err_tok_t;

endpackage

// File: rtl/rdcpl_err_pipe.sv
module rdcpl_err_pipe
  import rdcpl_err_pkg::*;
#(
  parameter int LAT_CONV = 2,
  parameter int LAT_EXT  = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  err_tok_t tok_in,
  output logic     fire_perr,
  output logic     fire_serr
);

  localparam int LAT_MAX = (LAT_EXT > LAT_CONV) ? LAT_EXT : LAT_CONV;
  localparam int DEPTH   = LAT_MAX - 1;
  localparam int TAP_C   = LAT_CONV - 2;
  localparam int TAP_E   = LAT_EXT - 2;

  err_tok_t stg_q [DEPTH];
  err_tok_t stg_d [DEPTH];
  logic [DEPTH-1:0] busy;
  logic shift_en;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stg
    if (s == 0) begin : g_head
      assign stg_d[s] = tok_in;
    end else begin : g_body
      assign stg_d[s] = stg_q[s-1];
    end
    assign busy[s] = stg_q[s].perr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[s] <= '0;
      end else if (shift_en) begin
        stg_q[s] <= stg_d[s];
      end
    end
  end

  // Advance only while a token is entering or still in flight
  assign shift_en = tok_in.perr | (|busy);

  always_comb begin
    fire_perr = (stg_q[TAP_C].perr & ~stg_q[TAP_C].ext)
              | (stg_q[TAP_E].perr &  stg_q[TAP_E].ext);
    fire_serr = (stg_q[TAP_C].serr & ~stg_q[TAP_C].ext)
              | (stg_q[TAP_E].serr &  stg_q[TAP_E].ext);
  end

endmodule

// File: rtl/rdcpl_sticky_bank.sv
module rdcpl_sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r, q_nxt;
  logic         upd_en;

  // Set takes priority over a simultaneous clear
  always_comb begin
    upd_en = (|set_i) | (|clr_i);
    q_nxt  = (q_r & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (upd_en) begin
      q_r <= q_nxt;
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/rdcpl_err_log.sv
module rdcpl_err_log #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [ADDR_W-1:0] addr_hi,
  input  logic [ATTR_W-1:0] attr,
  output logic              valid,
  output logic              ovf,
  output logic [ADDR_W-1:0] log_lo,
  output logic [ADDR_W-1:0] log_hi,
  output logic [ATTR_W-1:0] log_at
);

  logic              valid_r, valid_nxt;
  logic              ovf_r, ovf_nxt;
  logic              take;
  logic              flag_en;
  logic [ADDR_W-1:0] lo_r, hi_r;
  logic [ATTR_W-1:0] at_r;

  always_comb begin
    take      = cap_req & (~valid_r | clr);
    flag_en   = cap_req | clr;
    valid_nxt = take | (valid_r & ~clr);
    ovf_nxt   = (cap_req & valid_r & ~clr) | (ovf_r & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_r <= 1'b0;
      ovf_r   <= 1'b0;
    end else if (flag_en) begin
      valid_r <= valid_nxt;
      ovf_r   <= ovf_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_r <= '0;
      hi_r <= '0;
      at_r <= '0;
    end else if (take) begin
      lo_r <= addr_lo;
      hi_r <= addr_hi;
      at_r <= attr;
    end
  end

  assign valid  = valid_r;
  assign ovf    = ovf_r;
  assign log_lo = lo_r;
  assign log_hi = hi_r;
  assign log_at = at_r;

endmodule

// File: rtl/rdcpl_err_ctrl.sv
module rdcpl_err_ctrl
  import rdcpl_err_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ATTR_W   = 16,
  parameter int LAT_CONV = 2,
  parameter int LAT_EXT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_strobe,
  input  logic [ADDR_W-1:0] err_addr_lo,
  input  logic [ADDR_W-1:0] err_addr_hi,
  input  logic [ATTR_W-1:0] err_attr,
  input  logic              mode_ext,
  input  logic              mode_ecc,
  input  logic              cmd_perr_resp,
  input  logic              cmd_serr_en,
  input  logic              ctl_rec_en,
  input  logic              msk_dpe,
  input  logic              msk_mpe,
  input  logic              msk_serr,
  input  logic              en_serr_det,
  input  logic [STS_W-1:0]  w1c_sts,
  input  logic [IRQ_W-1:0]  w1c_irq,
  input  logic              log_clr,
  output logic              perr_n,
  output logic              serr_n,
  output logic              cpl_abort,
  output logic [STS_W-1:0]  sts,
  output logic [IRQ_W-1:0]  irq_sts,
  output logic              log_valid,
  output logic              log_ovf,
  output logic [ADDR_W-1:0] log_addr_lo,
  output logic [ADDR_W-1:0] log_addr_hi,
  output logic [ATTR_W-1:0] log_attr
);

  err_tok_t         tok;
  logic             fire_perr, fire_serr;
  logic             perr_q, perr_nxt;
  logic             serr_q, serr_nxt;
  logic             out_en;
  logic [STS_W-1:0] sts_set;
  logic [IRQ_W-1:0] irq_set;
  logic             log_req;

  // Enables are sampled in the errored data phase itself
  always_comb begin
    tok.perr = err_strobe & cmd_perr_resp;
    tok.serr = err_strobe & cmd_perr_resp & cmd_serr_en & ~ctl_rec_en;
    tok.ext  = mode_ext;
  end

  rdcpl_err_pipe #(
    .LAT_CONV (LAT_CONV),
    .LAT_EXT  (LAT_EXT)
  ) i_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_in    (tok),
    .fire_perr (fire_perr),
    .fire_serr (fire_serr)
  );

  // Output pulse registers
  always_comb begin
    out_en   = fire_perr | perr_q | fire_serr | serr_q;
    perr_nxt = fire_perr;
    serr_nxt = fire_serr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      serr_q <= 1'b0;
    end else if (out_en) begin
      perr_q <= perr_nxt;
      serr_q <= serr_nxt;
    end
  end

  assign perr_n    = ~perr_q;
  assign serr_n    = ~serr_q;
  assign cpl_abort = perr_q;

  // Status and interrupt set terms
  always_comb begin
    sts_set           = '0;
    sts_set[STS_DPE]  = err_strobe;
    sts_set[STS_MPE]  = fire_perr;
    sts_set[STS_SERR] = fire_serr;

    irq_set           = '0;
    irq_set[IRQ_DPE]  = err_strobe & ~msk_dpe;
    irq_set[IRQ_MPE]  = fire_perr  & ~msk_mpe;
    irq_set[IRQ_SERR] = fire_serr  & ~msk_serr;
    irq_set[IRQ_SDET] = fire_serr  &  en_serr_det;
  end

  rdcpl_sticky_bank #(.W(STS_W)) i_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sts_set),
    .clr_i (w1c_sts),
    .q_o   (sts)
  );

  rdcpl_sticky_bank #(.W(IRQ_W)) i_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (irq_set),
    .clr_i (w1c_irq),
    .q_o   (irq_sts)
  );

  assign log_req = err_strobe & mode_ext & mode_ecc;

  rdcpl_err_log #(
    .ADDR_W (ADDR_W),
    .ATTR_W (ATTR_W)
  ) i_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_req (log_req),
    .clr     (log_clr),
    .addr_lo (err_addr_lo),
    .addr_hi (err_addr_hi),
    .attr    (err_attr),
    .valid   (log_valid),
    .ovf     (log_ovf),
    .log_lo  (log_addr_lo),
    .log_hi  (log_addr_hi),
    .log_at  (log_attr)
  );

endmodule

// File: rtl/rdcpl_err_chk.sv
module rdcpl_err_chk #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_strobe,
  input logic              mode_ext,
  input logic              cmd_perr_resp,
  input logic              en_serr_det,
  input logic [2:0]        w1c_sts,
  input logic              log_clr,
  input logic              perr_n,
  input logic              serr_n,
  input logic              cpl_abort,
  input logic [2:0]        sts,
  input logic [3:0]        irq_sts,
  input logic              log_valid,
  input logic [ADDR_W-1:0] log_addr_lo,
  input logic [ATTR_W-1:0] log_attr
);

  // Latencies below match the default 2/3-clock parameters
  a_r1_conv_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && cmd_perr_resp && !mode_ext) |=> ##1 !perr_n);

  a_r2_ext_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && cmd_perr_resp && mode_ext) |=> ##2 !perr_n);

  a_r4_serr_within_perr: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> !perr_n);

  a_r5_abort_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && cmd_perr_resp && !mode_ext) |=> ##1 cpl_abort);

  a_r6_detect_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_strobe |=> sts[0]);

  a_r6_mpe_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> sts[1]);

  a_r8_seen_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!serr_n && $past(en_serr_det)) |-> irq_sts[3]);

  a_r9_only_cleared_by_sw: assert property (@(posedge clk) disable iff (!rst_n)
    !(|($past(sts) & ~sts & ~$past(w1c_sts))));

  a_r11_log_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_clr) |=> (log_valid && $stable(log_addr_lo) && $stable(log_attr)));

endmodule

bind rdcpl_err_ctrl rdcpl_err_chk #(
  .ADDR_W (ADDR_W),
  .ATTR_W (ATTR_W)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .err_strobe    (err_strobe),
  .mode_ext      (mode_ext),
  .cmd_perr_resp (cmd_perr_resp),
  .en_serr_det   (en_serr_det),
  .w1c_sts       (w1c_sts),
  .log_clr       (log_clr),
  .perr_n        (perr_n),
  .serr_n        (serr_n),
  .cpl_abort     (cpl_abort),
  .sts           (sts),
  .irq_sts       (irq_sts),
  .log_valid     (log_valid),
  .log_addr_lo   (log_addr_lo),
  .log_attr      (log_attr)
);

// File: tb/test_rdcpl_err_ctrl.sv
module test_rdcpl_err_ctrl;

  localparam int AW = 32;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          err_strobe;
  logic [AW-1:0] err_addr_lo, err_addr_hi;
  logic [TW-1:0] err_attr;
  logic          mode_ext, mode_ecc;
  logic          cmd_perr_resp, cmd_serr_en, ctl_rec_en;
  logic          msk_dpe, msk_mpe, msk_serr, en_serr_det;
  logic [2:0]    w1c_sts;
  logic [3:0]    w1c_irq;
  logic          log_clr;
  logic          perr_n, serr_n, cpl_abort;
  logic [2:0]    sts;
  logic [3:0]    irq_sts;
  logic          log_valid, log_ovf;
  logic [AW-1:0] log_addr_lo, log_addr_hi;
  logic [TW-1:0] log_attr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  rdcpl_err_ctrl #(.ADDR_W(AW), .ATTR_W(TW)) i_rdcpl_err_ctrl (
    .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe),
    .err_addr_lo(err_addr_lo), .err_addr_hi(err_addr_hi), .err_attr(err_attr),
    .mode_ext(mode_ext), .mode_ecc(mode_ecc),
    .cmd_perr_resp(cmd_perr_resp), .cmd_serr_en(cmd_serr_en), .ctl_rec_en(ctl_rec_en),
    .msk_dpe(msk_dpe), .msk_mpe(msk_mpe), .msk_serr(msk_serr), .en_serr_det(en_serr_det),
    .w1c_sts(w1c_sts), .w1c_irq(w1c_irq), .log_clr(log_clr),
    .perr_n(perr_n), .serr_n(serr_n), .cpl_abort(cpl_abort),
    .sts(sts), .irq_sts(irq_sts), .log_valid(log_valid), .log_ovf(log_ovf),
    .log_addr_lo(log_addr_lo), .log_addr_hi(log_addr_hi), .log_attr(log_attr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Strobe for one cycle; returns at the negedge after the capturing edge
  task automatic pulse_err(input logic [AW-1:0] lo, input logic [AW-1:0] hi, input logic [TW-1:0] at);
    @(negedge clk);
    err_strobe = 1'b1; err_addr_lo = lo; err_addr_hi = hi; err_attr = at;
    @(negedge clk);
    err_strobe = 1'b0;
  endtask

  task automatic clr_all();
    @(negedge clk);
    w1c_sts = '1; w1c_irq = '1; log_clr = 1'b1;
    @(negedge clk);
    w1c_sts = '0; w1c_irq = '0; log_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R6 reset sts", sts, 3'b000);
    chk("R7 reset irq_sts", irq_sts, 4'b0000);
    chk("R1 reset perr_n", perr_n, 1'b1);
    chk("R4 reset serr_n", serr_n, 1'b1);
    chk("R5 reset cpl_abort", cpl_abort, 1'b0);
    chk("R10 reset log_valid", log_valid, 1'b0);
  endtask

  task automatic t_conv();
    mode_ext = 1'b0; mode_ecc = 1'b0;
    clr_all();
    pulse_err(32'h1000, 32'h0, 16'h1);
    chk("R1 conv cycle1 perr_n", perr_n, 1'b1);
    chk("R6 detected set", sts, 3'b001);
    chk("R7 irq detected", irq_sts, 4'b0001);
    idle(1);
    chk("R1 conv cycle2 perr_n", perr_n, 1'b0);
    chk("R4 serr_n with perr", serr_n, 1'b0);
    chk("R5 abort with perr", cpl_abort, 1'b1);
    chk("R6 all status set", sts, 3'b111);
    chk("R7 R8 all irq set", irq_sts, 4'b1111);
    idle(1);
    chk("R1 conv cycle3 perr_n", perr_n, 1'b1);
    chk("R4 serr_n single", serr_n, 1'b1);
    chk("R5 abort single", cpl_abort, 1'b0);
    idle(2);
  endtask

  task automatic t_ext();
    mode_ext = 1'b1; mode_ecc = 1'b0;
    clr_all();
    pulse_err(32'h2000, 32'h0, 16'h2);
    chk("R10 no log without ecc", log_valid, 1'b0);
    idle(1);
    chk("R2 ext cycle2 perr_n", perr_n, 1'b1);
    idle(1);
    chk("R2 ext cycle3 perr_n", perr_n, 1'b0);
    chk("R5 ext abort", cpl_abort, 1'b1);
    idle(1);
    chk("R2 ext cycle4 perr_n", perr_n, 1'b1);
    idle(2);
    mode_ext = 1'b0;
  endtask

  task automatic t_no_resp();
    logic seen;
    seen = 1'b0;
    cmd_perr_resp = 1'b0;
    clr_all();
    pulse_err(32'h3000, 32'h0, 16'h3);
    for (int i = 0; i < 4; i++) begin
      if (!perr_n || !serr_n || cpl_abort) seen = 1'b1;
      @(negedge clk);
    end
    chk("R3 no pulse without response", seen, 1'b0);
    chk("R3 R6 only detected status", sts, 3'b001);
    cmd_perr_resp = 1'b1;
  endtask

  task automatic t_serr_block();
    ctl_rec_en = 1'b1;
    clr_all();
    pulse_err(32'h4000, 32'h0, 16'h4);
    idle(1);
    chk("R4 recover blocks perr? no", perr_n, 1'b0);
    chk("R4 recover blocks serr_n", serr_n, 1'b1);
    chk("R4 serr status stays clear", sts[2], 1'b0);
    chk("R8 seen stays clear", irq_sts[3], 1'b0);
    idle(2);
    ctl_rec_en = 1'b0; cmd_serr_en = 1'b0;
    pulse_err(32'h4100, 32'h0, 16'h4);
    idle(1);
    chk("R4 disabled serr_n", serr_n, 1'b1);
    idle(2);
    cmd_serr_en = 1'b1;
  endtask

  task automatic t_masks();
    msk_dpe = 1'b1; msk_mpe = 1'b1; msk_serr = 1'b1; en_serr_det = 1'b0;
    clr_all();
    pulse_err(32'h5000, 32'h0, 16'h5);
    idle(2);
    chk("R6 status ignores masks", sts, 3'b111);
    chk("R7 R8 masked irq", irq_sts, 4'b0000);
    msk_dpe = 1'b0; msk_mpe = 1'b0; msk_serr = 1'b0; en_serr_det = 1'b1;
  endtask

  task automatic t_w1c();
    clr_all();
    pulse_err(32'h6000, 32'h0, 16'h6);
    idle(3);
    @(negedge clk); w1c_sts = 3'b010;
    @(negedge clk); w1c_sts = 3'b000;
    chk("R9 one bit cleared", sts, 3'b101);
    chk("R9 irq untouched", irq_sts, 4'b1111);
    @(negedge clk); w1c_irq = 4'b1000;
    @(negedge clk); w1c_irq = 4'b0000;
    chk("R9 irq bit cleared", irq_sts, 4'b0111);
    // collision: set and clear of bit 0 on one edge
    @(negedge clk);
    err_strobe = 1'b1; w1c_sts = 3'b001; w1c_irq = 4'b0001;
    @(negedge clk);
    err_strobe = 1'b0; w1c_sts = 3'b000; w1c_irq = 4'b0000;
    chk("R9 set wins status", sts[0], 1'b1);
    chk("R9 set wins irq", irq_sts[0], 1'b1);
    idle(3);
  endtask

  task automatic t_log();
    mode_ext = 1'b1; mode_ecc = 1'b1;
    clr_all();
    pulse_err(32'hA1A1_0001, 32'hB1B1_0001, 16'hC001);
    chk("R10 log valid", log_valid, 1'b1);
    chk("R10 log lo", log_addr_lo, 32'hA1A1_0001);
    chk("R10 log hi", log_addr_hi, 32'hB1B1_0001);
    chk("R10 log attr", log_attr, 16'hC001);
    chk("R11 no overflow yet", log_ovf, 1'b0);
    pulse_err(32'hA2A2_0002, 32'hB2B2_0002, 16'hC002);
    chk("R11 log held", log_addr_lo, 32'hA1A1_0001);
    chk("R11 overflow set", log_ovf, 1'b1);
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    chk("R11 clr drops valid", log_valid, 1'b0);
    chk("R11 clr drops ovf", log_ovf, 1'b0);
    pulse_err(32'hA3A3_0003, 32'hB3B3_0003, 16'hC003);
    // release and new error on the same edge
    @(negedge clk);
    log_clr = 1'b1; err_strobe = 1'b1;
    err_addr_lo = 32'hA4A4_0004; err_addr_hi = 32'hB4B4_0004; err_attr = 16'hC004;
    @(negedge clk);
    log_clr = 1'b0; err_strobe = 1'b0;
    chk("R11 collision valid", log_valid, 1'b1);
    chk("R11 collision new record", log_addr_hi, 32'hB4B4_0004);
    chk("R11 collision ovf clear", log_ovf, 1'b0);
    mode_ecc = 1'b0;
    clr_all();
    pulse_err(32'hDEAD, 32'hBEEF, 16'h7);
    chk("R10 ecc off no log", log_valid, 1'b0);
    mode_ext = 1'b0; mode_ecc = 1'b1;
    pulse_err(32'hDEAD, 32'hBEEF, 16'h7);
    chk("R10 conventional no log", log_valid, 1'b0);
    mode_ecc = 1'b0;
    idle(3);
  endtask

  task automatic t_b2b();
    mode_ext = 1'b0;
    @(negedge clk); err_strobe = 1'b1;
    @(negedge clk);
    chk("R12 conv b2b c1", perr_n, 1'b1);
    @(negedge clk); err_strobe = 1'b0;
    chk("R12 conv b2b first", perr_n, 1'b0);
    @(negedge clk);
    chk("R12 conv b2b second", perr_n, 1'b0);
    @(negedge clk);
    chk("R12 conv b2b end", perr_n, 1'b1);
    idle(2);
    mode_ext = 1'b1;
    @(negedge clk); err_strobe = 1'b1;
    @(negedge clk);
    @(negedge clk); err_strobe = 1'b0;
    chk("R12 ext b2b c2", perr_n, 1'b1);
    @(negedge clk);
    chk("R12 ext b2b first", perr_n, 1'b0);
    @(negedge clk);
    chk("R12 ext b2b second", perr_n, 1'b0);
    @(negedge clk);
    chk("R12 ext b2b end", perr_n, 1'b1);
    mode_ext = 1'b0;
    idle(2);
  endtask

  initial begin
    rst_n = 1'b0;
    err_strobe = 1'b0; err_addr_lo = '0; err_addr_hi = '0; err_attr = '0;
    mode_ext = 1'b0; mode_ecc = 1'b0;
    cmd_perr_resp = 1'b1; cmd_serr_en = 1'b1; ctl_rec_en = 1'b0;
    msk_dpe = 1'b0; msk_mpe = 1'b0; msk_serr = 1'b0; en_serr_det = 1'b1;
    w1c_sts = '0; w1c_irq = '0; log_clr = 1'b0;
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_conv();
    t_ext();
    t_no_resp();
    t_serr_block();
    t_masks();
    t_w1c();
    t_log();
    t_b2b();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule